// File: doc/BRIEF.md
# Hoppable NCO Phase Accumulator

This block produces the phase word that drives an oscillator lookup. A 32-bit frequency (tuning) word is added into a 32-bit accumulator once per accepted input sample. The upper 16 bits of the accumulator, plus a programmable 16-bit phase offset, form the output phase. The offset spans 0 up to 2π·(2^16−1)/2^16 radians, so the sum wraps modulo 2^16.

Software writes the tuning word as two 16-bit halves over a small register port. The halves land in shadow storage and leave the running accumulator untouched. The shadow word reaches the active register only on a commit: a hop strobe, or the channel leaving sleep. When the holdoff of the surrounding sync logic is set to one, the `hold_one` input is raised and every write to a half commits at once. A mode input picks what a hop does to the phase. It either carries on from the current accumulator value (phase-continuous) or restarts from zero.

Top module: `nco_phase_gen`

## Requirements
- R1: After reset, `phase_vld` is 0, `phase_out` is 0, and the accumulator, the active and shadow tuning words and the offset are all zero. Samples taken before any commit therefore yield phase 0 plus offset.
- R2: A write with `wr_sel`=0 loads tuning bits [15:0] into the shadow, and `wr_sel`=1 loads bits [31:16]. With `hold_one` low and no commit, neither write changes the phase sequence. A write with `wr_sel`=3 has no effect on any state.
- R3: A cycle with `hop_stb` high copies the shadow tuning word into the active register. A half written in that same cycle is included in the copy.
- R4: A cycle in which `sleep` is low after being high in the previous cycle (wake) copies the shadow tuning word into the active register.
- R5: With `hold_one` high, a write with `wr_sel` 0 or 1 updates the shadow and the active tuning word in the same clock edge.
- R6: With `clear_on_hop` low, a hop keeps the accumulator value. A sample in the hop cycle still adds the old tuning word, and the new word is added from the next sample on.
- R7: With `clear_on_hop` high, a hop sets the accumulator to zero regardless of `sample_en`. The new word is added from the next sample on.
- R8: A write with `wr_sel`=2 sets the 16-bit phase offset. The output is (accumulator[31:16] + offset) mod 2^16.
- R9: The accumulator advances only in cycles where `sample_en` is high and `sleep` is low. In any other cycle it holds, apart from a clearing hop.
- R10: `phase_vld` is high exactly one cycle after an accepted sample. `phase_out` then shows the accumulator value from before that sample's addition, plus the offset, and it holds while `phase_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 tuning low half, 1 tuning high half, 2 offset, 3 none |
| wr_data | input | 16 | Write data |
| hold_one | input | 1 | Tuning writes commit immediately |
| clear_on_hop | input | 1 | 1: hop zeroes the accumulator; 0: hop keeps phase |
| hop_stb | input | 1 | Hop commit strobe |
| sleep | input | 1 | Channel asleep; falling edge is a wake commit |
| sample_en | input | 1 | Input sample valid |
| phase_out | output | 16 | Output phase word |
| phase_vld | output | 1 | Output phase valid |

## Verification
The bench goes after commit timing. A design that copied the shadow on every write would bend the phase ramp at once with `hold_one` low. A design that took the pre-write shadow in a hop cycle with a concurrent write would lose that half. The hop cycle itself is probed with a sample present. A continuous hop that adds the new word in that cycle shifts every later phase, and a clearing hop that lets the sample's addition through leaves a non-zero start. Sleep sweeps with `sample_en` held high catch an accumulator that advances while asleep or misses the wake commit. Offset sweeps run up to 0xFFFF, where a missing wraparound or a wrong bit slice shows at once.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    SEL_TUNE_LO = 2'd0,
    SEL_TUNE_HI = 2'd1,
    SEL_OFFSET  = 2'd2,
    SEL_NONE    = 2'd3
  } nco_sel_e;

  localparam int unsigned TUNE_W  = 32;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned PHASE_W = 16;
endpackage

// File: rtl/nco_tune_bank.sv
// Shadow and active tuning word, plus phase offset register.
module nco_tune_bank #(
  parameter int unsigned TUNE_W = 32,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              hold_one,
  input  logic              hop_stb,
  input  logic              sleep,
  output logic [TUNE_W-1:0] tune_act,
  output logic [OFS_W-1:0]  phase_ofs
);
  localparam int unsigned NHALF   = TUNE_W / HALF_W;
  localparam int unsigned OFS_SEL = NHALF;

  logic [TUNE_W-1:0] shadow_q, shadow_nxt;
  logic [TUNE_W-1:0] act_q, act_nxt;
  logic [OFS_W-1:0]  ofs_q, ofs_nxt;
  logic              sleep_q;
  logic              wake;
  logic              tune_hit;
  logic              commit;

  // per-half shadow next-state
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic hit;
    always_comb begin
      hit = wr_en && (wr_sel == SEL_W'(h));
      shadow_nxt[h*HALF_W +: HALF_W] = hit ? wr_data
                                           : shadow_q[h*HALF_W +: HALF_W];
    end
  end

  always_comb begin
    tune_hit = wr_en && (wr_sel < SEL_W'(NHALF));
    wake     = sleep_q && !sleep;
    commit   = hop_stb || wake || (hold_one && tune_hit);
    act_nxt  = commit ? shadow_nxt : act_q;
    ofs_nxt  = (wr_en && (wr_sel == SEL_W'(OFS_SEL))) ? wr_data[OFS_W-1:0] : ofs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
      ofs_q    <= '0;
      sleep_q  <= 1'b0;
    end else begin
      shadow_q <= shadow_nxt;
      act_q    <= act_nxt;
      ofs_q    <= ofs_nxt;
      sleep_q  <= sleep;
    end
  end

  assign tune_act  = act_q;
  assign phase_ofs = ofs_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hop_stb && !(sleep_q && !sleep) && !(hold_one && wr_en && wr_sel < SEL_W'(NHALF)))
      |=> $stable(tune_act));

  assert_hop_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_stb && !wr_en) |=> (tune_act == $past(shadow_q)));

  assert_wake_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sleep) && !sleep && !wr_en) |=> (tune_act == $past(shadow_q)));

  assert_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_one && wr_en && wr_sel == '0) |=> (tune_act[HALF_W-1:0] == $past(wr_data)));

  assert_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_W'(OFS_SEL)) |=> (phase_ofs == $past(wr_data[OFS_W-1:0])));
endmodule

// File: rtl/nco_accum.sv
// Phase accumulator with clearing hop.
module nco_accum #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             hop_clear,
  input  logic [ACC_W-1:0] tune,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] acc_q, acc_nxt;

  always_comb begin
    acc_nxt = acc_q;
    if (hop_clear)    acc_nxt = '0;
    else if (step_en) acc_nxt = acc_q + tune;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nxt;
  end

  assign acc = acc_q;

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hop_clear |=> (acc == '0));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !hop_clear) |=> $stable(acc));

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !hop_clear) |=> (acc == $past(acc) + $past(tune)));
endmodule

// File: rtl/nco_phase_out.sv
// Offset addition and registered output.
module nco_phase_out #(
  parameter int unsigned PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic [PHASE_W-1:0] acc_top,
  input  logic [PHASE_W-1:0] phase_ofs,
  output logic [PHASE_W-1:0] phase_out,
  output logic               phase_vld
);
  logic [PHASE_W-1:0] ph_q, ph_nxt;
  logic               vld_q;

  always_comb begin
    ph_nxt = step_en ? (acc_top + phase_ofs) : ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      ph_q  <= ph_nxt;
      vld_q <= step_en;
    end
  end

  assign phase_out = ph_q;
  assign phase_vld = vld_q;

  assert_vld_R10: assert property (@(posedge clk) disable iff (!rst_n)
    phase_vld |-> $past(step_en));

  assert_hold_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(phase_out));
endmodule

// File: rtl/nco_phase_gen.sv
module nco_phase_gen #(
  parameter int unsigned TUNE_W  = nco_pkg::TUNE_W,
  parameter int unsigned HALF_W  = nco_pkg::HALF_W,
  parameter int unsigned PHASE_W = nco_pkg::PHASE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [HALF_W-1:0]  wr_data,
  input  logic               hold_one,
  input  logic               clear_on_hop,
  input  logic               hop_stb,
  input  logic               sleep,
  input  logic               sample_en,
  output logic [PHASE_W-1:0] phase_out,
  output logic               phase_vld
);
  logic [TUNE_W-1:0]  tune_act;
  logic [PHASE_W-1:0] phase_ofs;
  logic [TUNE_W-1:0]  acc;
  logic               step_en;
  logic               hop_clear;

  always_comb begin
    step_en   = sample_en && !sleep;
    hop_clear = hop_stb && clear_on_hop;
  end

  nco_tune_bank #(
    .TUNE_W(TUNE_W), .HALF_W(HALF_W), .OFS_W(PHASE_W), .SEL_W(2)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .hold_one(hold_one), .hop_stb(hop_stb),
    .sleep(sleep), .tune_act(tune_act), .phase_ofs(phase_ofs)
  );

  nco_accum #(.ACC_W(TUNE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .hop_clear(hop_clear),
    .tune(tune_act), .acc(acc)
  );

  nco_phase_out #(.PHASE_W(PHASE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .acc_top(acc[TUNE_W-1 -: PHASE_W]), .phase_ofs(phase_ofs),
    .phase_out(phase_out), .phase_vld(phase_vld)
  );

  assert_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!phase_vld && phase_out == '0));
endmodule

// File: tb/tb_nco_phase_gen.sv
module tb_nco_phase_gen;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic        hold_one = 0, clear_on_hop = 0, hop_stb = 0, sleep = 0, sample_en = 0;
  logic [15:0] phase_out;
  logic        phase_vld;

  int checks = 0, fails = 0;
  string tag = "R1";

  logic [31:0] m_acc = 0, m_act = 0, m_sh = 0;
  logic [15:0] m_ofs = 0, m_out = 0;
  logic        m_vld = 0, m_slq = 0;

  always #(CLK_P/2) clk = ~clk;

  nco_phase_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hold_one(hold_one), .clear_on_hop(clear_on_hop), .hop_stb(hop_stb),
    .sleep(sleep), .sample_en(sample_en), .phase_out(phase_out), .phase_vld(phase_vld)
  );

  task automatic chk(input string t, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // one clock: expected values follow the requirements
  task automatic step();
    logic        take;
    logic [31:0] sh_n;
    logic        wake, tune_wr;
    @(posedge clk);
    take = sample_en && !sleep;                    // R9
    m_vld = take;                                  // R10
    if (take) m_out = m_acc[31:16] + m_ofs;        // R8, R10
    if (hop_stb && clear_on_hop) m_acc = 0;        // R7
    else if (take) m_acc = m_acc + m_act;          // R6
    sh_n = m_sh;
    if (wr_en && wr_sel == 0) sh_n[15:0]  = wr_data; // R2
    if (wr_en && wr_sel == 1) sh_n[31:16] = wr_data;
    tune_wr = wr_en && wr_sel < 2;
    wake = m_slq && !sleep;                        // R4
    if (hop_stb || wake || (hold_one && tune_wr)) m_act = sh_n; // R3, R5
    if (wr_en && wr_sel == 2) m_ofs = wr_data;     // R8
    m_sh = sh_n;
    m_slq = sleep;
    #1;
    chk({tag, " vld"}, 32'(phase_vld), 32'(m_vld));
    chk({tag, " phase"}, 32'(phase_out), 32'(m_out));
    wr_en = 0; hop_stb = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; step();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(CLK_P*190000);
    fails++;
    $display("FAIL R10 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset vld", 32'(phase_vld), 0);
    chk("R1 reset phase", 32'(phase_out), 0);
    @(negedge clk); rst_n = 1;
    tag = "R1"; sample_en = 1; run(4);

    // R2 shadow writes hidden; code 3 ignored
    tag = "R2";
    wr(0, 16'h0000); wr(1, 16'h0100); run(5);
    wr(3, 16'hFFFF); run(3);

    // R3 + R6: continuous hop with sample in hop cycle
    tag = "R6"; clear_on_hop = 0; hop_stb = 1; step(); run(6);
    tag = "R3"; wr(1, 16'h0040); hop_stb = 1; wr(0, 16'h8000); run(6);

    // R8 offset sweep including top value
    tag = "R8";
    for (int o = 0; o <= 16; o++) begin
      wr(2, (o == 16) ? 16'hFFFF : 16'(o * 16'h1111)); run(3);
    end

    // R9 + R4: sleeping with samples, wake commit
    tag = "R9"; wr(1, 16'h0333); sleep = 1; run(8);
    sample_en = 0; run(3); sample_en = 1;
    tag = "R4"; sleep = 0; run(6);

    // R5 immediate update
    tag = "R5"; hold_one = 1; wr(0, 16'h1234); run(3); wr(1, 16'h0021); run(4); hold_one = 0;

    // R7 clearing hop, with and without a sample present
    tag = "R7"; clear_on_hop = 1; wr(1, 16'h0700); hop_stb = 1; step(); run(4);
    sample_en = 0; hop_stb = 1; step(); sample_en = 1; run(4);

    // R10 near-exhaustive sweep over mode bits and random stimulus
    tag = "R10";
    for (int mode = 0; mode < 4; mode++) begin
      clear_on_hop = mode[0]; hold_one = mode[1];
      for (int i = 0; i < 3000; i++) begin
        wr_en = ($urandom % 5) == 0; wr_sel = 2'($urandom); wr_data = 16'($urandom);
        hop_stb = ($urandom % 23) == 0;
        sleep = (($urandom % 17) == 0) ? ~sleep : sleep;
        sample_en = ($urandom % 3) != 0;
        step();
      end
    end
    summary();
    $finish;
  end
endmodule